// File: doc/BRIEF.md
# Linear CCD Clock and Shutter Timing Generator

This block drives a six-line color linear CCD from one system clock. For every line it raises a readout gate inside guard intervals, then runs a complementary transfer clock pair for a programmed number of pixels. Alongside runs a second complementary pair at twice the transfer rate that clocks the output registers, plus a narrow charge-reset pulse. Copies of the transfer phases for the last transfer stages come out as separate pins. Three shutter outputs, one per color, set each color's integration time. Each shutter goes high with the readout gate and falls at a pixel index set per color.

A line starts with a single-cycle trigger. The line length and the three shutter release indices are captured when the trigger is accepted. A line-start pulse marks the fall of the readout gate, and a busy flag covers the whole line. A shutter edge must never land inside the effective-pixel window. A release index that falls inside that window is therefore moved to the first pixel after it. Line lengths below the sensor's minimum are raised to that minimum.

All outputs come from registers and move together, one system clock after the internal sequencer state.

Top module: `ccd_timing_gen`

## Requirements
- R1: During and after reset, before any trigger: gate_o=0, xa_o=1, xb_o=0, ra_o=0, rb_o=1, fdr_o=0, shut_o=0, line_start_o=0, busy_o=0.
- R2: xb_o is always the inverse of xa_o. xa_last_o and xa_last2_o always equal xa_o, and xb_last_o always equals xb_o. Each pixel is one full transfer period (XFER_PER = 4*HALF_REG cycles), in which xa_o is low for the first half and high for the second. A line therefore has exactly as many xa_o falling edges as pixels.
- R3: rb_o is always the inverse of ra_o. ra_o rises twice per pixel and stays high HALF_REG cycles each time (50% duty at twice the transfer rate). It is low outside the pixel phase.
- R4: After an accepted trigger, busy_o rises. xa_o stays high for PRE_CYC cycles, then gate_o is high for exactly GATE_CYC cycles, and xa_o does not change while gate_o is high.
- R5: After gate_o falls, xa_o stays high for exactly POST_CYC cycles before its first falling edge.
- R6: fdr_o is high for FDR_W cycles at the start of every ra_o high half, so there are two pulses per pixel, and it is never high while ra_o is low.
- R7: The line length is line_len_i pixels, raised to MIN_LINE when smaller. It and shut_pos_i are captured at the accepted trigger, and later changes do not affect the running line.
- R8: line_start_o is high for one cycle per line, in the cycle gate_o is first low after its high period.
- R9: busy_o is high for exactly PRE_CYC+GATE_CYC+POST_CYC+len*XFER_PER cycles. A trigger while busy_o is high starts no further line.
- R10: shut_o[c] rises in the cycle gate_o rises. It falls in the same cycle as the xa_o falling edge that starts pixel index shut_pos_i[c] (index 0 = first pixel, i.e. the first xa_o falling edge of the line).
- R11: A release index in [EFF_FIRST, EFF_LAST] is moved to EFF_LAST+1. No shutter changes level while pixels EFF_FIRST to EFF_LAST are being transferred.
- R12: A release index at or beyond the line length leaves that shutter high for the whole line.
- R13: The three shutter outputs follow their own indices independently in the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Line trigger, accepted when idle |
| line_len_i | input | CNT_W | Pixels per line (raised to MIN_LINE) |
| shut_pos_i | input | N_COLOR*CNT_W | Per-color shutter release pixel index, element c for shut_o[c] |
| gate_o | output | 1 | Readout gate pulse |
| xa_o | output | 1 | Transfer clock phase A |
| xb_o | output | 1 | Transfer clock phase B |
| xa_last_o | output | 1 | Last-stage copy of phase A |
| xa_last2_o | output | 1 | Second last-stage copy of phase A |
| xb_last_o | output | 1 | Last-stage copy of phase B |
| ra_o | output | 1 | Output-register clock phase A |
| rb_o | output | 1 | Output-register clock phase B |
| fdr_o | output | 1 | Charge reset pulse |
| shut_o | output | N_COLOR | Per-color shutter |
| line_start_o | output | 1 | One-cycle pulse at gate fall |
| busy_o | output | 1 | Line in progress |

## Verification
The bench targets the edges around the readout gate. It measures the hold before the gate, the gate width and the hold after it. A sequencer off by one on a guard counter would shorten the hold of the transfer clock and spoil the charge transfer from the gate. It also checks the shutter release indices at 0, just before the effective window, at both window edges and beyond the line. A wrong deferral would move a shutter edge into the effective pixels or release it one pixel early or late. It checks a too-short length request and triggers or setting changes that arrive mid-line. A design that failed to clamp or capture would run the wrong number of pixels, or start a second line while busy.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_GATE  = 3'd2,
        ST_POST  = 3'd3,
        ST_SHIFT = 3'd4
    } tg_state_e;

endpackage

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int HALF_REG = 12,
    parameter int PRE_CYC  = 3,
    parameter int GATE_CYC = 75,
    parameter int POST_CYC = 75,
    parameter int MIN_LINE = 5394,
    localparam int REG_PER  = 2 * HALF_REG,
    localparam int XFER_PER = 2 * REG_PER,
    localparam int PW       = $clog2(XFER_PER),
    localparam int GMAX1    = (PRE_CYC > GATE_CYC) ? PRE_CYC : GATE_CYC,
    localparam int GMAX     = (GMAX1 > POST_CYC) ? GMAX1 : POST_CYC,
    localparam int GW       = $clog2(GMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] line_len_i,
    output tg_state_e        state_o,
    output logic [PW-1:0]    ph_o,
    output logic [CNT_W-1:0] pix_o,
    output logic             accept_o,
    output logic             gate_entry_o,
    output logic             post_entry_o
);

    localparam logic [GW-1:0]    PRE_LAST  = GW'(PRE_CYC - 1);
    localparam logic [GW-1:0]    GATE_LAST = GW'(GATE_CYC - 1);
    localparam logic [GW-1:0]    POST_LAST = GW'(POST_CYC - 1);
    localparam logic [PW-1:0]    PH_LAST   = PW'(XFER_PER - 1);
    localparam logic [CNT_W-1:0] LEN_MIN   = CNT_W'(MIN_LINE);

    typedef struct packed {
        tg_state_e        st;
        logic [GW-1:0]    gc;
        logic [PW-1:0]    ph;
        logic [CNT_W-1:0] pix;
        logic [CNT_W-1:0] len;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;

    always_comb begin
        seq_d  = seq_q;
        accept = (seq_q.st == ST_IDLE) && start_i;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st  = ST_PRE;
                    seq_d.gc  = '0;
                    seq_d.len = (line_len_i < LEN_MIN) ? LEN_MIN : line_len_i;
                end
            end
            ST_PRE: begin
                if (seq_q.gc == PRE_LAST) begin
                    seq_d.st = ST_GATE;
                    seq_d.gc = '0;
                end else begin
                    seq_d.gc = seq_q.gc + 1'b1;
                end
            end
            ST_GATE: begin
                if (seq_q.gc == GATE_LAST) begin
                    seq_d.st = ST_POST;
                    seq_d.gc = '0;
                end else begin
                    seq_d.gc = seq_q.gc + 1'b1;
                end
            end
            ST_POST: begin
                if (seq_q.gc == POST_LAST) begin
                    seq_d.st  = ST_SHIFT;
                    seq_d.gc  = '0;
                    seq_d.ph  = '0;
                    seq_d.pix = '0;
                end else begin
                    seq_d.gc = seq_q.gc + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (seq_q.ph == PH_LAST) begin
                    seq_d.ph = '0;
                    if (seq_q.pix == seq_q.len - 1'b1) begin
                        seq_d.st  = ST_IDLE;
                        seq_d.pix = '0;
                    end else begin
                        seq_d.pix = seq_q.pix + 1'b1;
                    end
                end else begin
                    seq_d.ph = seq_q.ph + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, gc: '0, ph: '0, pix: '0, len: LEN_MIN};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o      = seq_q.st;
    assign ph_o         = seq_q.ph;
    assign pix_o        = seq_q.pix;
    assign accept_o     = accept;
    assign gate_entry_o = (seq_q.st == ST_GATE) && (seq_q.gc == '0);
    assign post_entry_o = (seq_q.st == ST_POST) && (seq_q.gc == '0);

    // R7: the pixel index never runs past the captured line length
    a_r7_pix_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SHIFT) |-> (seq_q.pix < seq_q.len));

    // R7: the captured length never drops below the minimum
    a_r7_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE) |-> (seq_q.len >= LEN_MIN));

    // R9: a trigger while busy leaves the sequence untouched
    a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_GATE) |=> (seq_q.st inside {ST_GATE, ST_POST}));

endmodule

// File: rtl/ccd_tg_clkgen.sv
module ccd_tg_clkgen
    import ccd_tg_pkg::*;
#(
    parameter int HALF_REG = 12,
    parameter int FDR_W    = 2,
    localparam int REG_PER  = 2 * HALF_REG,
    localparam int XFER_PER = 2 * REG_PER,
    localparam int PW       = $clog2(XFER_PER)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tg_state_e     state_i,
    input  logic [PW-1:0] ph_i,
    input  logic          post_entry_i,
    output logic          gate_o,
    output logic          xa_o,
    output logic          ra_o,
    output logic          fdr_o,
    output logic          line_start_o,
    output logic          busy_o
);

    localparam logic [PW-1:0] REG_P = PW'(REG_PER);
    localparam logic [PW-1:0] HALF  = PW'(HALF_REG);
    localparam logic [PW-1:0] FDRW  = PW'(FDR_W);

    typedef struct packed {
        logic gate;
        logic xa;
        logic ra;
        logic fdr;
        logic ls;
        logic busy;
    } clk_t;

    clk_t clk_d, clk_q;
    logic          shift;
    logic [PW-1:0] sub;

    always_comb begin
        shift      = (state_i == ST_SHIFT);
        sub        = (ph_i >= REG_P) ? (ph_i - REG_P) : ph_i;
        clk_d.gate = (state_i == ST_GATE);
        clk_d.xa   = shift ? (ph_i >= REG_P) : 1'b1;
        clk_d.ra   = shift && (sub < HALF);
        clk_d.fdr  = shift && (sub < FDRW);
        clk_d.ls   = post_entry_i;
        clk_d.busy = (state_i != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= '{gate: 1'b0, xa: 1'b1, ra: 1'b0, fdr: 1'b0, ls: 1'b0, busy: 1'b0};
        end else begin
            clk_q <= clk_d;
        end
    end

    assign gate_o       = clk_q.gate;
    assign xa_o         = clk_q.xa;
    assign ra_o         = clk_q.ra;
    assign fdr_o        = clk_q.fdr;
    assign line_start_o = clk_q.ls;
    assign busy_o       = clk_q.busy;

    // R4: the transfer clock is held high and steady under the gate
    a_r4_gate_holds_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q.gate |-> (clk_q.xa && $stable(clk_q.xa)));

    // R5: the transfer clock is still high as the gate falls
    a_r5_hold_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_q.gate) |-> clk_q.xa);

    // R6: the reset pulse sits inside the register clock high half
    a_r6_pulse_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q.fdr |-> clk_q.ra);

    // R8: line start marks the gate fall
    a_r8_ls_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q.ls |-> $fell(clk_q.gate));

    // R4: the gate only rises while a line is in progress
    a_r4_gate_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q.gate) |-> clk_q.busy);

endmodule

// File: rtl/ccd_tg_shutter.sv
module ccd_tg_shutter
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HALF_REG  = 12,
    parameter int EFF_FIRST = 41,
    parameter int EFF_LAST  = 5390,
    localparam int XFER_PER = 4 * HALF_REG,
    localparam int PW       = $clog2(XFER_PER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [CNT_W-1:0] pos_i,
    input  logic             gate_entry_i,
    input  tg_state_e        state_i,
    input  logic [PW-1:0]    ph_i,
    input  logic [CNT_W-1:0] pix_i,
    output logic             shut_o
);

    localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(EFF_FIRST);
    localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(EFF_LAST);
    localparam logic [CNT_W-1:0] WIN_OUT = CNT_W'(EFF_LAST + 1);

    typedef struct packed {
        logic [CNT_W-1:0] tgt;
        logic             shut;
    } sh_t;

    sh_t  sh_d, sh_q;
    logic in_win_req;
    logic in_win_now;

    always_comb begin
        sh_d       = sh_q;
        in_win_req = (pos_i >= WIN_LO) && (pos_i <= WIN_HI);
        in_win_now = (state_i == ST_SHIFT) && (pix_i >= WIN_LO) && (pix_i <= WIN_HI);
        if (accept_i) begin
            sh_d.tgt = in_win_req ? WIN_OUT : pos_i;
        end
        if (gate_entry_i) begin
            sh_d.shut = 1'b1;
        end else if ((state_i == ST_SHIFT) && (ph_i == '0) && (pix_i == sh_q.tgt)) begin
            sh_d.shut = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{tgt: '0, shut: 1'b0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign shut_o = sh_q.shut;

    // R11: no shutter edge while effective pixels are moving
    a_r11_window_stable: assert property (@(posedge clk) disable iff (!rst_n)
        in_win_now |=> $stable(sh_q.shut));

    // R10: the shutter is high once the gate has been entered
    a_r10_rise_with_gate: assert property (@(posedge clk) disable iff (!rst_n)
        gate_entry_i |=> sh_q.shut);

    // R11: a captured target never points into the window
    a_r11_target_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_IDLE) |-> !((sh_q.tgt >= WIN_LO) && (sh_q.tgt <= WIN_HI)));

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int N_COLOR   = 3,
    parameter int HALF_REG  = 12,
    parameter int FDR_W     = 2,
    parameter int PRE_CYC   = 3,
    parameter int GATE_CYC  = 75,
    parameter int POST_CYC  = 75,
    parameter int MIN_LINE  = 5394,
    parameter int EFF_FIRST = 41,
    parameter int EFF_LAST  = 5390,
    localparam int XFER_PER = 4 * HALF_REG,
    localparam int PW       = $clog2(XFER_PER)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [CNT_W-1:0]                line_len_i,
    input  logic [N_COLOR-1:0][CNT_W-1:0]   shut_pos_i,
    output logic                            gate_o,
    output logic                            xa_o,
    output logic                            xb_o,
    output logic                            xa_last_o,
    output logic                            xa_last2_o,
    output logic                            xb_last_o,
    output logic                            ra_o,
    output logic                            rb_o,
    output logic                            fdr_o,
    output logic [N_COLOR-1:0]              shut_o,
    output logic                            line_start_o,
    output logic                            busy_o
);

    tg_state_e        state;
    logic [PW-1:0]    ph;
    logic [CNT_W-1:0] pix;
    logic             accept;
    logic             gate_entry;
    logic             post_entry;
    logic             xa;
    logic             ra;

    ccd_tg_seq #(
        .CNT_W    (CNT_W),
        .HALF_REG (HALF_REG),
        .PRE_CYC  (PRE_CYC),
        .GATE_CYC (GATE_CYC),
        .POST_CYC (POST_CYC),
        .MIN_LINE (MIN_LINE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .line_len_i   (line_len_i),
        .state_o      (state),
        .ph_o         (ph),
        .pix_o        (pix),
        .accept_o     (accept),
        .gate_entry_o (gate_entry),
        .post_entry_o (post_entry)
    );

    ccd_tg_clkgen #(
        .HALF_REG (HALF_REG),
        .FDR_W    (FDR_W)
    ) u_clk (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_i      (state),
        .ph_i         (ph),
        .post_entry_i (post_entry),
        .gate_o       (gate_o),
        .xa_o         (xa),
        .ra_o         (ra),
        .fdr_o        (fdr_o),
        .line_start_o (line_start_o),
        .busy_o       (busy_o)
    );

    for (genvar c = 0; c < N_COLOR; c++) begin : g_shut
        ccd_tg_shutter #(
            .CNT_W     (CNT_W),
            .HALF_REG  (HALF_REG),
            .EFF_FIRST (EFF_FIRST),
            .EFF_LAST  (EFF_LAST)
        ) u_sh (
            .clk          (clk),
            .rst_n        (rst_n),
            .accept_i     (accept),
            .pos_i        (shut_pos_i[c]),
            .gate_entry_i (gate_entry),
            .state_i      (state),
            .ph_i         (ph),
            .pix_i        (pix),
            .shut_o       (shut_o[c])
        );
    end

    assign xa_o       = xa;
    assign xb_o       = ~xa;
    assign xa_last_o  = xa;
    assign xa_last2_o = xa;
    assign xb_last_o  = ~xa;
    assign ra_o       = ra;
    assign rb_o       = ~ra;

endmodule

// File: tb/sim_ccd_timing_gen.sv
`timescale 1ns/1ps
module sim_ccd_timing_gen;

    localparam int CW   = 8;
    localparam int HR   = 3;
    localparam int FW   = 2;
    localparam int PRE  = 3;
    localparam int GAT  = 8;
    localparam int PST  = 8;
    localparam int MINL = 14;
    localparam int EF   = 4;
    localparam int EL   = 10;
    localparam int XP   = 4 * HR;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [CW-1:0]       line_len_i = '0;
    logic [2:0][CW-1:0]  shut_pos_i = '0;
    logic gate, xa, xb, xal, xal2, xbl, ra, rb, fdr, ls, busy;
    logic [2:0] shut;

    ccd_timing_gen #(
        .CNT_W(CW), .N_COLOR(3), .HALF_REG(HR), .FDR_W(FW), .PRE_CYC(PRE),
        .GATE_CYC(GAT), .POST_CYC(PST), .MIN_LINE(MINL), .EFF_FIRST(EF), .EFF_LAST(EL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_len_i(line_len_i),
        .shut_pos_i(shut_pos_i), .gate_o(gate), .xa_o(xa), .xb_o(xb),
        .xa_last_o(xal), .xa_last2_o(xal2), .xb_last_o(xbl), .ra_o(ra), .rb_o(rb),
        .fdr_o(fdr), .shut_o(shut), .line_start_o(ls), .busy_o(busy)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // per-line measurements, cleared when busy rises
    int fcnt, xlow, rrise, rhigh, fdrhi, fdrrise, bcyc, pre, prebad, ghi, post;
    int lsn, lsbad, cmpbad, wchg, brise;
    int fidx [3];
    logic [2:0] sgate;
    bit gseen, gdone, xfseen, mon_en;
    logic pxa, pra, pfdr, pg, pb;
    logic [2:0] ps;

    initial begin
        brise = 0; mon_en = 0; cmpbad = 0;
        pxa = 1; pra = 0; pfdr = 0; pg = 0; pb = 0; ps = '0;
    end

    always @(negedge clk) begin
        if (mon_en) begin
            if (busy && !pb) begin
                fcnt = 0; xlow = 0; rrise = 0; rhigh = 0; fdrhi = 0; fdrrise = 0;
                bcyc = 0; pre = 0; prebad = 0; ghi = 0; post = 0; lsn = 0; lsbad = 0;
                wchg = 0; sgate = 'x; gseen = 0; gdone = 0; xfseen = 0;
                for (int c = 0; c < 3; c++) fidx[c] = -1;
                brise++;
            end
            if (pxa && !xa) begin fcnt++; xfseen = 1; end
            if (busy) bcyc++;
            if (gate) begin gseen = 1; ghi++; end
            if (busy && !gseen) begin pre++; if (!xa) prebad++; end
            if (pg && !gate) gdone = 1;
            if (busy && gdone && !xfseen) post++;
            if (busy && !xa) xlow++;
            if (ra && !pra) rrise++;
            if (ra) rhigh++;
            if (fdr) fdrhi++;
            if (fdr && !pfdr) fdrrise++;
            if (ls) begin lsn++; if (!(pg && !gate)) lsbad++; end
            if (gate && !pg) sgate = shut;
            for (int c = 0; c < 3; c++) begin
                if (ps[c] && !shut[c]) fidx[c] = fcnt;
                if (busy && (shut[c] != ps[c]) && fcnt >= EF + 1 && fcnt <= EL + 1) wchg++;
            end
            if (xb == xa || xal != xa || xal2 != xa || xbl != xb || rb == ra) cmpbad++;
            pxa = xa; pra = ra; pfdr = fdr; pg = gate; pb = busy; ps = shut;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_line(input int len, input int s0, input int s1, input int s2);
        @(negedge clk);
        line_len_i = CW'(len);
        shut_pos_i[0] = CW'(s0); shut_pos_i[1] = CW'(s1); shut_pos_i[2] = CW'(s2);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        do begin @(negedge clk); #1; end while (!busy);
        do begin @(negedge clk); #1; end while (busy);
    endtask

    task automatic line_shape(input string tag, input int len);
        chk({tag, " R2 xa falls"}, fcnt, len);
        chk({tag, " R2 xa low cycles"}, xlow, len * 2 * HR);
        chk({tag, " R3 ra rises"}, rrise, 2 * len);
        chk({tag, " R3 ra high cycles"}, rhigh, 2 * len * HR);
        chk({tag, " R6 fdr pulses"}, fdrrise, 2 * len);
        chk({tag, " R6 fdr high cycles"}, fdrhi, 2 * len * FW);
        chk({tag, " R4 pre cycles"}, pre, PRE);
        chk({tag, " R4 xa low in pre"}, prebad, 0);
        chk({tag, " R4 gate width"}, ghi, GAT);
        chk({tag, " R5 hold after gate"}, post, PST);
        chk({tag, " R8 line start count"}, lsn, 1);
        chk({tag, " R8 line start at fall"}, lsbad, 0);
        chk({tag, " R9 busy cycles"}, bcyc, PRE + GAT + PST + len * XP);
        chk({tag, " R10 shutters at gate"}, int'(sgate), 7);
        chk({tag, " R11 window edges"}, wchg, 0);
    endtask

    task automatic t_reset;
        #1;
        chk("R1 gate", gate, 0);  chk("R1 xa", xa, 1);  chk("R1 xb", xb, 0);
        chk("R1 ra", ra, 0);      chk("R1 rb", rb, 1);  chk("R1 fdr", fdr, 0);
        chk("R1 shut", int'(shut), 0); chk("R1 ls", ls, 0); chk("R1 busy", busy, 0);
    endtask

    task automatic t_basic;
        run_line(14, 2, 5, 20);
        line_shape("basic", 14);
        chk("R10 color0 idx2", fidx[0], 3);
        chk("R11 color1 idx5 deferred", fidx[1], EL + 2);
        chk("R12 color2 beyond line", fidx[2], -1);
        chk("R12 color2 high at end", shut[2], 1);
    endtask

    task automatic t_clamp;
        run_line(5, 0, 10, 3);
        line_shape("clamp", MINL);
        chk("R10 color0 idx0", fidx[0], 1);
        chk("R11 color1 upper edge", fidx[1], EL + 2);
        chk("R13 color2 idx3", fidx[2], 4);
    endtask

    task automatic t_long;
        run_line(16, 4, 13, 15);
        line_shape("long", 16);
        chk("R11 color0 lower edge", fidx[0], EL + 2);
        chk("R13 color1 idx13", fidx[1], 14);
        chk("R13 color2 idx15", fidx[2], 16);
    endtask

    task automatic t_busy_ignore;
        int b0;
        b0 = brise;
        @(negedge clk);
        line_len_i = CW'(14);
        shut_pos_i[0] = CW'(2); shut_pos_i[1] = CW'(2); shut_pos_i[2] = CW'(2);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        line_len_i = CW'(30);
        shut_pos_i[0] = '0; shut_pos_i[1] = '0; shut_pos_i[2] = '0;
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        do begin @(negedge clk); #1; end while (busy);
        repeat (10) @(negedge clk);
        #1;
        chk("R9 one line for two triggers", brise - b0, 1);
        chk("R9 idle after line", busy, 0);
        chk("R7 length captured", fcnt, 14);
        chk("R7 shutter index captured", fidx[1], 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1;
        t_reset();
        t_basic();
        t_clamp();
        t_long();
        t_busy_ignore();
        chk("R2 R3 complement and copies", cmpbad, 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule